// File: doc/BRIEF.md
# Error Event Collector with Escalating Watchdog

This block gathers single-cycle error pulses from a set of sources and latches each one into a sticky bit of a per-group raw status register. Event input `i` lands in group `i / EVENTS_PER_GROUP`, at bit `i % EVENTS_PER_GROUP`. Group 0 therefore holds the lowest-numbered inputs, which is where error aggregator outputs are meant to be wired. While any raw bit that its group's enable mask allows is set, the block holds a non-maskable interrupt high toward the CPU.

If software lets an error sit, a high-priority watchdog escalates. The watchdog arms when the interrupt rises and counts up to a programmable limit. If the raw status is still not fully cleared when it gets there, the block raises a reset request. Software, or boot code after a reset, clears raw bits by writing ones to the clear address. It can also force bits to one through the set address, which lets it test the interrupt path.

Register access uses a valid/ready request channel and a valid/ready read-response channel. A read returns its data one cycle after it is accepted. A write produces no response. A request is accepted on a rising edge where `req_valid` and `req_ready` are both high. `req_ready` drops while a read response is waiting and `rsp_ready` is low, so a slow response consumer stalls every further request. Once `rsp_valid` is high, the response holds its data until it is taken.

Top module: `esc_collector`

## Requirements
- R1: After reset every raw status bit is 0, every enable bit is 1, the timeout register holds DEF_TIMEOUT (1000), `nmi_o` and `wd_rst_req_o` are 0, and `rsp_valid` is 0.
- R2: A one-cycle pulse on `evt_i[i]` sets raw bit `i % EVENTS_PER_GROUP` of group `i / EVENTS_PER_GROUP` on the next edge. The bit stays set after the pulse ends. Group g's raw status reads back at address `4*g` and at `4*g+1`, in bits [EVENTS_PER_GROUP-1:0].
- R3: Writing to address `4*g` clears each group-g raw bit whose data bit is 1. Zero data bits leave their raw bits unchanged.
- R4: Writing to address `4*g+1` sets each group-g raw bit whose data bit is 1. Zero data bits leave their raw bits unchanged.
- R5: When an event pulse and a clear of the same bit fall in the same cycle, the event wins and the bit ends up set. Other bits in the same clear are still cleared.
- R6: `nmi_o` is high exactly while some raw bit is set whose enable bit is also set. Group g's enable mask is read/write at address `4*g+2`, one bit per raw bit.
- R7: Once `nmi_o` rises, if the raw status is not all zero the whole time, `wd_rst_req_o` rises T+2 cycles after `nmi_o` rises, where T is the timeout register. It then stays high until every raw bit is zero. It falls on the edge after the raw status becomes all zero.
- R8: Clearing every raw bit before expiry reloads the watchdog: the count at address `2^ADDR_W-3` reads 0, no reset request is raised, and the next interrupt gets the full T+2 cycle window again.
- R9: The timeout register is read/write at address `2^ADDR_W-4` (0x3C by default).
- R10: A read that is accepted returns the register value from the acceptance cycle, with `rsp_valid` high in the next cycle. The response holds stable until `rsp_ready` is high, and `req_ready` is low while it waits. Reads of unmapped addresses (group index at or above NUM_GROUPS, other than the watchdog addresses) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_GROUPS*EVENTS_PER_GROUP | Single-cycle error event pulses |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request can be accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response consumer ready |
| rsp_rdata | output | DATA_W | Read response data |
| nmi_o | output | 1 | Non-maskable interrupt request |
| wd_rst_req_o | output | 1 | Watchdog reset request |

## Verification
An incoming event pulse and a software write can hit the same raw status bit in the same clock cycle, and the block must resolve the conflict in the event's favour. The bench provokes this by driving `evt_i` in the same cycle as a clear write. That write names some bits that have an event and some that do not. A scoreboard read afterwards must show the pulsed bits set and the other named bits cleared. A second meeting point, the clear that lands near watchdog expiry, is judged by sampling `wd_rst_req_o` at fixed cycle offsets around the clear.

// File: rtl/esc_pkg.sv
package esc_pkg;
  // Offset of a register inside a group's four-word window
  localparam logic [1:0] OFS_CLEAR  = 2'd0;
  localparam logic [1:0] OFS_SET    = 2'd1;
  localparam logic [1:0] OFS_ENABLE = 2'd2;
  localparam logic [1:0] OFS_SPARE  = 2'd3;

  typedef enum logic [1:0] {
    WD_IDLE   = 2'd0,
    WD_COUNT  = 2'd1,
    WD_EXPIRE = 2'd2
  } wd_state_e;
endpackage

// File: rtl/esc_group.sv
module esc_group #(
  parameter int EPG = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [EPG-1:0] evt_i,
  input  logic [EPG-1:0] clr_i,
  input  logic [EPG-1:0] set_i,
  input  logic           en_we_i,
  input  logic [EPG-1:0] en_wdata_i,
  output logic [EPG-1:0] raw_o,
  output logic [EPG-1:0] en_o,
  output logic           hit_o,
  output logic           any_o
);
  logic [EPG-1:0] raw_q, raw_d, en_q;

  // events and software sets dominate software clears
  always_comb raw_d = (raw_q & ~clr_i) | set_i | evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
      en_q  <= '1;
    end else begin
      raw_q <= raw_d;
      if (en_we_i) en_q <= en_wdata_i;
    end
  end

  assign raw_o = raw_q;
  assign en_o  = en_q;
  assign hit_o = |(raw_q & en_q);
  assign any_o = |raw_q;
endmodule

// File: rtl/esc_watchdog.sv
module esc_watchdog
  import esc_pkg::*;
#(
  parameter int              WD_W        = 16,
  parameter logic [WD_W-1:0] DEF_TIMEOUT = 16'd1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            nmi_i,
  input  logic            any_raw_i,
  input  logic            to_we_i,
  input  logic [WD_W-1:0] to_wdata_i,
  output logic [WD_W-1:0] timeout_o,
  output logic [WD_W-1:0] count_o,
  output logic            rst_req_o
);
  wd_state_e       state_q;
  logic [WD_W-1:0] cnt_q, timeout_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timeout_q <= DEF_TIMEOUT;
      state_q   <= WD_IDLE;
      cnt_q     <= '0;
    end else begin
      if (to_we_i) timeout_q <= to_wdata_i;
      if (!any_raw_i) begin
        state_q <= WD_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          WD_IDLE:   if (nmi_i) begin
                       state_q <= WD_COUNT;
                       cnt_q   <= '0;
                     end
          WD_COUNT:  if (cnt_q >= timeout_q) state_q <= WD_EXPIRE;
                     else cnt_q <= cnt_q + 1'b1;
          WD_EXPIRE: state_q <= WD_EXPIRE;
          default:   state_q <= WD_IDLE;
        endcase
      end
    end
  end

  assign timeout_o = timeout_q;
  assign count_o   = cnt_q;
  assign rst_req_o = (state_q == WD_EXPIRE);
endmodule

// File: rtl/esc_regport.sv
module esc_regport
  import esc_pkg::*;
#(
  parameter int NG          = 2,
  parameter int EPG         = 8,
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 16,
  parameter int WD_W        = 16,
  parameter int WD_TO_ADDR  = 60,
  parameter int WD_CNT_ADDR = 61
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [DATA_W-1:0]       rsp_rdata,
  input  logic [NG-1:0][EPG-1:0]  raw_i,
  input  logic [NG-1:0][EPG-1:0]  en_i,
  input  logic [WD_W-1:0]         timeout_i,
  input  logic [WD_W-1:0]         count_i,
  output logic [NG-1:0][EPG-1:0]  clr_o,
  output logic [NG-1:0][EPG-1:0]  set_o,
  output logic [NG-1:0]           en_we_o,
  output logic [EPG-1:0]          en_wdata_o,
  output logic                    to_we_o,
  output logic [WD_W-1:0]         to_wdata_o
);
  localparam int GSEL_W = ADDR_W - 2;

  logic [GSEL_W-1:0] gsel;
  logic [1:0]        ofs;
  logic              accept, wr_acc, rd_acc;
  logic [DATA_W-1:0] rd_data, rsp_q;
  logic              rsp_vq;

  assign gsel      = req_addr[ADDR_W-1:2];
  assign ofs       = req_addr[1:0];
  assign req_ready = !rsp_vq || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign wr_acc    = accept && req_write;
  assign rd_acc    = accept && !req_write;

  for (genvar gi = 0; gi < NG; gi++) begin : g_dec
    logic hit_g;
    assign hit_g       = (gsel == GSEL_W'(gi));
    assign clr_o[gi]   = (wr_acc && hit_g && ofs == OFS_CLEAR) ? req_wdata[EPG-1:0] : '0;
    assign set_o[gi]   = (wr_acc && hit_g && ofs == OFS_SET)   ? req_wdata[EPG-1:0] : '0;
    assign en_we_o[gi] = wr_acc && hit_g && (ofs == OFS_ENABLE);
  end

  assign en_wdata_o = req_wdata[EPG-1:0];
  assign to_we_o    = wr_acc && (req_addr == ADDR_W'(WD_TO_ADDR));
  assign to_wdata_o = req_wdata[WD_W-1:0];

  always_comb begin
    rd_data = '0;
    for (int g = 0; g < NG; g++) begin
      if (gsel == GSEL_W'(g)) begin
        case (ofs)
          OFS_CLEAR, OFS_SET: rd_data[EPG-1:0] = raw_i[g];
          OFS_ENABLE:         rd_data[EPG-1:0] = en_i[g];
          default:            rd_data = '0;
        endcase
      end
    end
    if (req_addr == ADDR_W'(WD_TO_ADDR))  rd_data[WD_W-1:0] = timeout_i;
    if (req_addr == ADDR_W'(WD_CNT_ADDR)) rd_data[WD_W-1:0] = count_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vq <= 1'b0;
      rsp_q  <= '0;
    end else if (rd_acc) begin
      rsp_vq <= 1'b1;
      rsp_q  <= rd_data;
    end else if (rsp_ready) begin
      rsp_vq <= 1'b0;
    end
  end

  assign rsp_valid = rsp_vq;
  assign rsp_rdata = rsp_q;
endmodule

// File: rtl/esc_collector.sv
module esc_collector #(
  parameter int NUM_GROUPS       = 2,
  parameter int EVENTS_PER_GROUP = 8,
  parameter int ADDR_W           = 6,
  parameter int DATA_W           = 16,
  parameter int WD_W             = 16,
  parameter int DEF_TIMEOUT      = 1000
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_GROUPS*EVENTS_PER_GROUP-1:0] evt_i,
  input  logic                                   req_valid,
  output logic                                   req_ready,
  input  logic                                   req_write,
  input  logic [ADDR_W-1:0]                      req_addr,
  input  logic [DATA_W-1:0]                      req_wdata,
  output logic                                   rsp_valid,
  input  logic                                   rsp_ready,
  output logic [DATA_W-1:0]                      rsp_rdata,
  output logic                                   nmi_o,
  output logic                                   wd_rst_req_o
);
  localparam int EPG         = EVENTS_PER_GROUP;
  localparam int NUM_EVT     = NUM_GROUPS * EPG;
  localparam int WD_TO_ADDR  = (1 << ADDR_W) - 4;
  localparam int WD_CNT_ADDR = (1 << ADDR_W) - 3;

  logic [NUM_GROUPS-1:0][EPG-1:0] raw, en, clr, set;
  logic [NUM_GROUPS-1:0]          en_we, hit, any;
  logic [EPG-1:0]                 en_wdata;
  logic                           to_we, any_raw;
  logic [WD_W-1:0]                to_wdata, timeout, count;
  logic [NUM_EVT-1:0]             raw_flat;

  esc_regport #(
    .NG(NUM_GROUPS), .EPG(EPG), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .WD_W(WD_W), .WD_TO_ADDR(WD_TO_ADDR), .WD_CNT_ADDR(WD_CNT_ADDR)
  ) u_port (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_wdata,
    .rsp_valid, .rsp_ready, .rsp_rdata,
    .raw_i(raw), .en_i(en), .timeout_i(timeout), .count_i(count),
    .clr_o(clr), .set_o(set), .en_we_o(en_we), .en_wdata_o(en_wdata),
    .to_we_o(to_we), .to_wdata_o(to_wdata)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    esc_group #(.EPG(EPG)) u_grp (
      .clk, .rst_n,
      .evt_i(evt_i[g*EPG +: EPG]),
      .clr_i(clr[g]), .set_i(set[g]),
      .en_we_i(en_we[g]), .en_wdata_i(en_wdata),
      .raw_o(raw[g]), .en_o(en[g]), .hit_o(hit[g]), .any_o(any[g])
    );
    assign raw_flat[g*EPG +: EPG] = raw[g];
  end

  assign nmi_o   = |hit;
  assign any_raw = |any;

  esc_watchdog #(.WD_W(WD_W), .DEF_TIMEOUT(WD_W'(DEF_TIMEOUT))) u_wd (
    .clk, .rst_n, .nmi_i(nmi_o), .any_raw_i(any_raw),
    .to_we_i(to_we), .to_wdata_i(to_wdata),
    .timeout_o(timeout), .count_o(count), .rst_req_o(wd_rst_req_o)
  );
endmodule

// File: rtl/esc_collector_chk.sv
module esc_collector_chk #(
  parameter int EPG     = 8,
  parameter int NUM_EVT = 16,
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic [EPG-1:0]     wd_lo,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic               nmi_o,
  input logic               wd_rst_req_o,
  input logic [NUM_EVT-1:0] raw_flat
);
  logic wr_acc;
  assign wr_acc = req_valid && req_ready && req_write;

  // R2 / R5: every pulsed event is latched on the next edge, clears or not
  p_evt_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_i) |=> ((raw_flat & $past(evt_i)) == $past(evt_i)));

  // R3: a clear write to group 0 leaves no named bit set unless pulsed
  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == '0) |=>
      ((raw_flat[EPG-1:0] & $past(wd_lo) & ~$past(evt_i[EPG-1:0])) == '0));

  // R4: a set write to group 0 forces every named bit
  p_w1s_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && req_addr == ADDR_W'(1)) |=>
      ((raw_flat[EPG-1:0] & $past(wd_lo)) == $past(wd_lo)));

  // R6: interrupt only rises after an event or a register write
  p_nmi_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_o) |-> $past((|evt_i) || wr_acc));

  // R7: reset request drops once the raw status is empty
  p_rst_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_flat == '0) |=> !wd_rst_req_o);

  // R10: a pending response holds and blocks new requests
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));

  p_backpressure_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !req_ready);
endmodule

bind esc_collector esc_collector_chk #(
  .EPG(EPG), .NUM_EVT(NUM_EVT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .wd_lo(req_wdata[EPG-1:0]),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
  .nmi_o(nmi_o), .wd_rst_req_o(wd_rst_req_o), .raw_flat(raw_flat)
);

// File: tb/esc_collector_test.sv
module esc_collector_test;
  localparam int NG = 2, EPG = 8, AW = 6, DW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NG*EPG-1:0] evt_i = '0;
  logic            req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [AW-1:0]   req_addr = '0;
  logic [DW-1:0]   req_wdata = '0;
  logic            req_ready, rsp_valid, nmi_o, wd_rst_req_o;
  logic [DW-1:0]   rsp_rdata;

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [DW-1:0] exp_q[$];
  string         tag_q[$];

  always #10 clk = ~clk;  // 50 MHz

  esc_collector uut (
    .clk, .rst_n, .evt_i, .req_valid, .req_ready, .req_write, .req_addr,
    .req_wdata, .rsp_valid, .rsp_ready, .rsp_rdata, .nmi_o, .wd_rst_req_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // driver: entered and left at a falling edge
  task automatic issue(bit wr, logic [AW-1:0] a, logic [DW-1:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    issue(1'b1, a, d);
  endtask

  task automatic rd(logic [AW-1:0] a, logic [DW-1:0] exp, string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    issue(1'b0, a, '0);
  endtask

  task automatic pulse(logic [NG*EPG-1:0] v);
    evt_i = v;
    @(negedge clk);
    evt_i = '0;
  endtask

  // monitor: values 1 ns after the falling edge hold through the next rising edge
  always @(negedge clk) begin
    #1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) check("R10 unexpected response", 32'(rsp_rdata), 32'hDEAD);
      else begin
        automatic logic [DW-1:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, 32'(rsp_rdata), 32'(e));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 nmi", 32'(nmi_o), 0);
    check("R1 rst_req", 32'(wd_rst_req_o), 0);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    rd(6'd0, 16'h0000, "R1 raw g0");
    rd(6'd2, 16'h00FF, "R1 enable g0");
    rd(6'h3C, 16'd1000, "R1 timeout");

    // R2 latch and stickiness, two groups
    pulse(16'h0005);
    check("R2 nmi after event", 32'(nmi_o), 1);
    rd(6'd0, 16'h0005, "R2 raw g0");
    pulse(16'h0200);
    rd(6'd4, 16'h0002, "R2 raw g1 bit1");
    rd(6'd1, 16'h0005, "R2 g0 sticky via set addr");

    // R3 write-one-to-clear, zeros ignored
    wr(6'd0, 16'h0001);
    rd(6'd0, 16'h0004, "R3 clear bit0");
    wr(6'd0, 16'h0000);
    rd(6'd0, 16'h0004, "R3 zero write no effect");

    // R4 write-one-to-set
    wr(6'd1, 16'h0030);
    rd(6'd0, 16'h0034, "R4 set bits 4,5");
    wr(6'd5, 16'h0000);
    rd(6'd4, 16'h0002, "R4 zero set no effect");

    // R5 event and clear on the same bits in one cycle
    evt_i = 16'h000C;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 6'd0; req_wdata = 16'h001C;
    @(negedge clk);
    evt_i = '0; req_valid = 1'b0; req_write = 1'b0;
    rd(6'd0, 16'h002C, "R5 event beats clear");

    wr(6'd0, 16'h00FF);
    wr(6'd4, 16'h00FF);
    check("R6 nmi low when empty", 32'(nmi_o), 0);

    // R6 enable mask
    wr(6'd6, 16'h0000);
    wr(6'd5, 16'h0001);
    check("R6 masked bit no nmi", 32'(nmi_o), 0);
    rd(6'd4, 16'h0001, "R6 masked bit latched");
    wr(6'd6, 16'h00FF);
    check("R6 nmi after enable", 32'(nmi_o), 1);
    rd(6'd6, 16'h00FF, "R6 enable readback");
    wr(6'd4, 16'h00FF);
    check("R6 nmi after clear", 32'(nmi_o), 0);

    // R9 timeout register
    wr(6'h3C, 16'd5);
    rd(6'h3C, 16'd5, "R9 timeout readback");

    // R7 expiry at T+2 cycles after nmi rises
    pulse(16'h0001);
    repeat (6) @(negedge clk);
    check("R7 no reset at T+1", 32'(wd_rst_req_o), 0);
    @(negedge clk);
    check("R7 reset at T+2", 32'(wd_rst_req_o), 1);
    repeat (4) @(negedge clk);
    check("R7 reset held", 32'(wd_rst_req_o), 1);
    wr(6'd0, 16'h0001);
    check("R7 reset still high on clear edge", 32'(wd_rst_req_o), 1);
    @(negedge clk);
    check("R7 reset released", 32'(wd_rst_req_o), 0);

    // R8 clear before expiry reloads the watchdog
    pulse(16'h0002);
    repeat (4) @(negedge clk);
    wr(6'd0, 16'h0002);
    repeat (10) @(negedge clk);
    check("R8 no reset after early clear", 32'(wd_rst_req_o), 0);
    rd(6'h3D, 16'd0, "R8 count reloaded");
    pulse(16'h0004);
    repeat (6) @(negedge clk);
    check("R8 full window again", 32'(wd_rst_req_o), 0);
    @(negedge clk);
    check("R8 expiry after full window", 32'(wd_rst_req_o), 1);
    wr(6'd0, 16'h00FF);
    @(negedge clk);

    // R10 unmapped read and back-pressure
    rd(6'h20, 16'h0000, "R10 unmapped read");
    wr(6'd1, 16'h0080);
    rsp_ready = 1'b0;
    rd(6'd0, 16'h0080, "R10 held response");
    check("R10 ready low while pending", 32'(req_ready), 0);
    repeat (3) @(negedge clk);
    check("R10 valid held", 32'(rsp_valid), 1);
    check("R10 data held", 32'(rsp_rdata), 32'h0080);
    rsp_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 ready restored", 32'(req_ready), 1);
    check("R10 queue drained", 32'(exp_q.size()), 0);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule